// File: doc/BRIEF.md
# CPU Clock Source Switch Sequencer

This block orders the steps needed to move a CPU clock from one rate to another through a two-level clock multiplexer. A request carries the target rate in MHz. On acceptance, the block first moves the primary mux onto the alternate PLL. In the same cycle it writes the droop-monitor control value. It then hands a PLL target rate to an external programming agent and waits for that agent to report lock. Finally it selects the path that will carry the clock from then on.

A target at or above the threshold (600 MHz by default) runs straight from the PLL through its droop-monitored output. A target between half the threshold and the threshold cannot be produced directly, because the PLL only locks inside its upper band. For such a target the PLL is locked at twice the rate, and the clock is taken through the divide-by-2 input of the secondary mux. A target below half the threshold is refused. Both mux select fields live in a 32-bit control image. The block updates one field per write and leaves every other bit unchanged.

Top module: `cpu_clk_switch_seq`

## Requirements
- R1: After reset, `mux_ctrl_o` equals 0x0000_0003, meaning primary select 3 and secondary select 0. `busy_o`, `reject_o`, `timeout_o`, `pll_prog_start_o` and `droop_wr_o` are all low.
- R2: The primary select is held in `mux_ctrl_o[1:0]`. Its codes are 0 for the secondary-mux output, 1 for the direct PLL, 2 for the droop-monitored PLL and 3 for the alternate PLL. The secondary select is held in `mux_ctrl_o[3:2]`, with code 0 for the crystal reference and code 1 for PLL/2. `pmux_sel_o` and `smux_sel_o` read back these two fields, and bits [31:4] stay zero.
- R3: The clock edge that accepts a request makes the following changes together: `busy_o` goes high, the primary select becomes 3, and `droop_wr_o` pulses for one cycle with `droop_wdata_o` = 0xF.
- R4: One cycle after acceptance, `pll_prog_start_o` pulses for one cycle. At that point the primary select is already 3. For a target of 600 MHz or more, `pll_target_mhz_o` equals the target.
- R5: For a target from 300 up to but not including 600 MHz, `pll_target_mhz_o` is twice the target. After lock, the secondary select becomes 1 on one edge, and the primary select becomes 0 on the next edge.
- R6: For a target of 600 MHz or more, the edge after lock is seen sets the primary select to 2. The secondary field keeps its previous value.
- R7: A target below 300 MHz raises `reject_o` for one cycle, one edge after it is presented. The request changes neither field and never raises `busy_o`.
- R8: If `pll_locked_i` stays low for `TIMEOUT_CYC` cycles after the programming pulse, `timeout_o` pulses for one cycle and `busy_o` falls. The primary select stays at 3.
- R9: A request presented while `busy_o` is high is ignored. It causes no additional programming pulse, and it does not change the target or the final selects.
- R10: `busy_o` stays high until the edge that writes the final primary select, or until the timeout, and falls on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Rate request strobe |
| req_rate_mhz_i | input | RATE_W | Requested CPU rate in MHz |
| pll_locked_i | input | 1 | Lock indication from the PLL agent |
| busy_o | output | 1 | A sequence is in progress |
| reject_o | output | 1 | One-cycle pulse for a refused request |
| timeout_o | output | 1 | One-cycle pulse when lock wait expired |
| pll_prog_start_o | output | 1 | One-cycle pulse telling the agent to program the PLL |
| pll_target_mhz_o | output | RATE_W+1 | PLL rate to program, valid with and after the pulse |
| droop_wr_o | output | 1 | Write strobe for the droop-monitor control register |
| droop_wdata_o | output | 4 | Data for the droop-monitor write |
| mux_ctrl_o | output | 32 | Mux control register image |
| pmux_sel_o | output | 2 | Readback of the primary select field |
| smux_sel_o | output | 2 | Readback of the secondary select field |

## Verification
The hardest states to reach from the ports are the ones where the sequencer holds a partial result. One is the clock parked on the alternate PLL after a failed lock wait. The other is a secondary field left at 1 by an earlier divided-path request and then carried through a later direct-path request. To reach them, the bench's PLL responder can be told to withhold lock, which forces the timeout. The bench also chains a divided, a direct and a timed-out request, so the preserved secondary field is visible in the final image. A second request is injected while the first waits for lock, to show that it leaves no trace.

// File: rtl/cpu_clksw_pkg.sv
package cpu_clksw_pkg;
  typedef enum logic [1:0] {
    PSEL_DIV   = 2'd0,
    PSEL_PLL   = 2'd1,
    PSEL_DROOP = 2'd2,
    PSEL_ALT   = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    SSEL_XO   = 2'd0,
    SSEL_HALF = 2'd1
  } ssel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT,
    ST_SEL_P
  } seq_state_e;

  localparam int unsigned PSEL_LSB = 0;
  localparam int unsigned SSEL_LSB = 2;
  localparam logic [3:0]  DROOP_ON = 4'hF;
endpackage

// File: rtl/clksw_rate_decide.sv
module clksw_rate_decide #(
  parameter int unsigned RATE_W     = 12,
  parameter int unsigned THRESH_MHZ = 600
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              too_low_o,
  output logic              divided_o,
  output logic [RATE_W:0]   pll_rate_o
);
  localparam int unsigned MIN_MHZ = THRESH_MHZ / 2;
  localparam logic [RATE_W:0] THR = (RATE_W+1)'(THRESH_MHZ);
  localparam logic [RATE_W:0] MIN = (RATE_W+1)'(MIN_MHZ);

  logic [RATE_W:0] r_ext;
  assign r_ext      = {1'b0, rate_i};
  assign too_low_o  = r_ext < MIN;
  assign divided_o  = r_ext < THR;
  assign pll_rate_o = divided_o ? {rate_i, 1'b0} : r_ext;
endmodule

// File: rtl/clksw_lock_timer.sv
module clksw_lock_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/clksw_mux_image.sv
module clksw_mux_image #(
  parameter logic [31:0] RESET_VAL = 32'h0000_0003
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_p_i,
  input  logic [1:0]  p_val_i,
  input  logic        wr_s_i,
  input  logic [1:0]  s_val_i,
  output logic [31:0] image_o
);
  import cpu_clksw_pkg::*;

  logic [31:0] img_q, img_d;

  // one field per write; everything else carried over
  always_comb begin
    img_d = img_q;
    if (wr_p_i) img_d[PSEL_LSB +: 2] = p_val_i;
    if (wr_s_i) img_d[SSEL_LSB +: 2] = s_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) img_q <= RESET_VAL;
    else         img_q <= img_d;
  end

  assign image_o = img_q;
endmodule

// File: rtl/cpu_clk_switch_seq.sv
module cpu_clk_switch_seq #(
  parameter int unsigned RATE_W      = 12,
  parameter int unsigned THRESH_MHZ  = 600,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [RATE_W-1:0] req_rate_mhz_i,
  input  logic              pll_locked_i,
  output logic              busy_o,
  output logic              reject_o,
  output logic              timeout_o,
  output logic              pll_prog_start_o,
  output logic [RATE_W:0]   pll_target_mhz_o,
  output logic              droop_wr_o,
  output logic [3:0]        droop_wdata_o,
  output logic [31:0]       mux_ctrl_o,
  output logic [1:0]        pmux_sel_o,
  output logic [1:0]        smux_sel_o
);
  import cpu_clksw_pkg::*;

  seq_state_e      state_q, state_d;
  logic            too_low, divided;
  logic [RATE_W:0] pll_rate;
  logic            div_q;
  logic [RATE_W:0] tgt_q;
  logic            expired;
  logic            wr_p, wr_s;
  logic [1:0]      p_val, s_val;
  logic            accept, rej_d, to_d, prog_d;

  clksw_rate_decide #(.RATE_W(RATE_W), .THRESH_MHZ(THRESH_MHZ)) u_decide (
    .rate_i    (req_rate_mhz_i),
    .too_low_o (too_low),
    .divided_o (divided),
    .pll_rate_o(pll_rate)
  );

  clksw_lock_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT && !pll_locked_i),
    .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    wr_p    = 1'b0;
    wr_s    = 1'b0;
    p_val   = PSEL_ALT;
    s_val   = SSEL_HALF;
    accept  = 1'b0;
    rej_d   = 1'b0;
    to_d    = 1'b0;
    prog_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (too_low) rej_d = 1'b1;
        else begin
          accept  = 1'b1;
          wr_p    = 1'b1;
          p_val   = PSEL_ALT;
          state_d = ST_PROG;
        end
      end
      ST_PROG: begin
        prog_d  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (pll_locked_i) begin
          if (div_q) begin
            wr_s    = 1'b1;
            s_val   = SSEL_HALF;
            state_d = ST_SEL_P;
          end else begin
            wr_p    = 1'b1;
            p_val   = PSEL_DROOP;
            state_d = ST_IDLE;
          end
        end else if (expired) begin
          to_d    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SEL_P: begin
        wr_p    = 1'b1;
        p_val   = PSEL_DIV;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= ST_IDLE;
      div_q            <= 1'b0;
      tgt_q            <= '0;
      reject_o         <= 1'b0;
      timeout_o        <= 1'b0;
      pll_prog_start_o <= 1'b0;
      droop_wr_o       <= 1'b0;
    end else begin
      state_q          <= state_d;
      reject_o         <= rej_d;
      timeout_o        <= to_d;
      pll_prog_start_o <= prog_d;
      droop_wr_o       <= accept;
      if (accept) begin
        div_q <= divided;
        tgt_q <= pll_rate;
      end
    end
  end

  clksw_mux_image u_image (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_p_i (wr_p),
    .p_val_i(p_val),
    .wr_s_i (wr_s),
    .s_val_i(s_val),
    .image_o(mux_ctrl_o)
  );

  assign busy_o           = (state_q != ST_IDLE);
  assign pll_target_mhz_o = tgt_q;
  assign droop_wdata_o    = DROOP_ON;
  assign pmux_sel_o       = mux_ctrl_o[PSEL_LSB +: 2];
  assign smux_sel_o       = mux_ctrl_o[SSEL_LSB +: 2];
endmodule

// File: rtl/cpu_clk_switch_seq_chk.sv
module cpu_clk_switch_seq_chk #(
  parameter int unsigned RATE_W     = 12,
  parameter int unsigned THRESH_MHZ = 600
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              reject_o,
  input logic              timeout_o,
  input logic              pll_prog_start_o,
  input logic [RATE_W:0]   pll_target_mhz_o,
  input logic              droop_wr_o,
  input logic [3:0]        droop_wdata_o,
  input logic [31:0]       mux_ctrl_o
);
  a_r3_droop_at_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    droop_wr_o |-> (busy_o && mux_ctrl_o[1:0] == 2'd3 && droop_wdata_o == 4'hF));

  a_r4_parked_before_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_prog_start_o |-> (mux_ctrl_o[1:0] == 2'd3 && busy_o));

  a_r4_target_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_prog_start_o |-> (pll_target_mhz_o >= (RATE_W+1)'(THRESH_MHZ)));

  a_r7_reject_keeps_image: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> ($stable(mux_ctrl_o) && !busy_o));

  a_r8_timeout_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (mux_ctrl_o[1:0] == 2'd3 && !busy_o));

  a_r2_upper_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_ctrl_o[31:4] == 28'd0);

  a_r10_busy_ends_on_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (timeout_o || mux_ctrl_o[1:0] != 2'd3));

  a_r9_single_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_prog_start_o |=> !pll_prog_start_o);
endmodule

bind cpu_clk_switch_seq cpu_clk_switch_seq_chk #(
  .RATE_W(RATE_W), .THRESH_MHZ(THRESH_MHZ)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .busy_o          (busy_o),
  .reject_o        (reject_o),
  .timeout_o       (timeout_o),
  .pll_prog_start_o(pll_prog_start_o),
  .pll_target_mhz_o(pll_target_mhz_o),
  .droop_wr_o      (droop_wr_o),
  .droop_wdata_o   (droop_wdata_o),
  .mux_ctrl_o      (mux_ctrl_o)
);

// File: tb/cpu_clk_switch_seq_tb_top.sv
module cpu_clk_switch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RATE_W     = 12;
  localparam int TMO        = 16;

  typedef struct {
    int         kind;   // 0 done, 1 reject, 2 timeout
    logic [3:0] img;
    int         tgt;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [RATE_W-1:0] req_rate = '0;
  logic pll_locked = 1'b0;
  logic busy, reject, tmo, prog, droop_wr;
  logic [RATE_W:0] tgt;
  logic [3:0] droop_wdata;
  logic [31:0] mux_ctrl;
  logic [1:0] psel, ssel;

  int checks = 0, failures = 0;
  int prog_cnt = 0;
  int last_tgt = 0;
  bit lock_en = 1'b1;
  bit done_flag = 1'b0;
  logic [1:0] m_p = 2'd3, m_s = 2'd0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_clk_switch_seq #(.RATE_W(RATE_W), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_rate_mhz_i(req_rate),
    .pll_locked_i(pll_locked), .busy_o(busy), .reject_o(reject), .timeout_o(tmo),
    .pll_prog_start_o(prog), .pll_target_mhz_o(tgt), .droop_wr_o(droop_wr),
    .droop_wdata_o(droop_wdata), .mux_ctrl_o(mux_ctrl), .pmux_sel_o(psel), .smux_sel_o(ssel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  // PLL agent: lock a few cycles after the programming pulse
  initial begin
    forever begin
      @(negedge clk);
      if (prog) begin
        prog_cnt++;
        last_tgt = int'(tgt);
        if (lock_en) begin
          repeat (3) @(negedge clk);
          pll_locked = 1'b1;
          while (busy) @(negedge clk);
          pll_locked = 1'b0;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && (reject || tmo || (prev_busy && !busy))) begin
        int kind;
        kind = reject ? 1 : (tmo ? 2 : 0);
        if (sb.size() == 0) check(1'b0, "R9", "unexpected completion", kind, -1);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(kind == e.kind, e.req, "completion kind", kind, e.kind);
          check(mux_ctrl == {28'd0, e.img}, e.req, "mux image", mux_ctrl, {28'd0, e.img});
          check(psel == e.img[1:0] && ssel == e.img[3:2], "R2", "readback", {ssel, psel}, e.img);
          if (e.kind != 1) check(last_tgt == e.tgt, e.req, "pll target", last_tgt, e.tgt);
          done_flag = 1'b1;
        end
      end
      prev_busy = busy;
    end
  end

  task automatic request(input int rate, input bit locks);
    exp_t e;
    int pc0;
    lock_en = locks;
    pc0 = prog_cnt;
    if (rate < 300) begin
      e.kind = 1; e.tgt = 0; e.req = "R7";
    end else begin
      e.tgt = (rate < 600) ? 2*rate : rate;
      if (!locks) begin
        m_p = 2'd3; e.kind = 2; e.req = "R8";
      end else if (rate < 600) begin
        m_p = 2'd0; m_s = 2'd1; e.kind = 0; e.req = "R5";
      end else begin
        m_p = 2'd2; e.kind = 0; e.req = "R6";
      end
    end
    e.img = {m_s, m_p};
    sb.push_back(e);
    done_flag = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_rate  = RATE_W'(rate);
    @(negedge clk);
    req_valid = 1'b0;
    if (rate >= 300) begin
      check(busy && psel == 2'd3, "R3", "park on accept", {busy, psel}, 3'b111);
      check(droop_wr && droop_wdata == 4'hF, "R3", "droop write", {droop_wr, droop_wdata}, 5'h1F);
      @(negedge clk);
      check(prog == 1'b1 && psel == 2'd3, "R4", "prog pulse parked", {prog, psel}, 3'b111);
      if (rate == 1000 && locks) begin
        // R9: second request while busy
        @(negedge clk);
        req_valid = 1'b1;
        req_rate  = RATE_W'(400);
        @(negedge clk);
        req_valid = 1'b0;
      end
    end else begin
      check(!busy, "R7", "not busy on reject", busy, 0);
    end
    for (int i = 0; i < TMO + 20 && !done_flag; i++) @(negedge clk);
    check(done_flag, e.req, "completion seen", done_flag, 1);
    if (rate >= 300)
      check(prog_cnt == pc0 + 1, "R9", "programming pulses", prog_cnt - pc0, 1);
    repeat (2) @(negedge clk);
    check(!busy, "R10", "idle after sequence", busy, 0);
  endtask

  // R10: busy stays high while waiting, falls exactly with the final write
  task automatic busy_window;
    exp_t e;
    lock_en = 1'b1;
    m_p = 2'd2;
    e.kind = 0; e.img = {m_s, m_p}; e.tgt = 700; e.req = "R10";
    sb.push_back(e);
    @(negedge clk); req_valid = 1'b1; req_rate = RATE_W'(700);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(busy && psel == 2'd3, "R10", "busy before final select", {busy, psel}, 3'b111);
      @(negedge clk);
    end
    check(!busy && psel == 2'd2, "R10", "busy low with final select", {busy, psel}, 3'b010);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mux_ctrl == 32'h3, "R1", "reset image", mux_ctrl, 32'h3);
    check(!busy && !reject && !tmo && !prog && !droop_wr, "R1", "reset strobes",
          {busy, reject, tmo, prog, droop_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    request(250, 1'b1);   // R7 below minimum
    request(299, 1'b1);   // R7 boundary
    request(300, 1'b1);   // R5 lower boundary, target 600
    request(599, 1'b1);   // R5 upper boundary, target 1198
    request(600, 1'b1);   // R6 boundary, secondary kept at 1
    request(1000, 1'b1);  // R6 with R9 injection
    busy_window();
    request(450, 1'b1);   // R5 from direct path
    request(800, 1'b0);   // R8 timeout, parked
    request(100, 1'b1);   // R7 while parked: no change
    request(2000, 1'b1);  // R6 recovery
    check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule